// File: doc/BRIEF.md
# Interrupt Redirection Entry with Remote-IRR Tracking

This block is one routing slot of an I/O interrupt controller. It watches a single device interrupt line and raises a delivery request toward a downstream interrupt acceptor. The request carries the slot's programmed vector and a flag that marks system-management routing. Software programs the slot through a small register port. One address holds the entry itself, with its vector, routing kind, trigger kind, mask and a status bit. The other address is an end-of-interrupt (EOI) register.

In edge mode each rising edge of the line yields one request. In level mode a request is issued while the line is high. Once the acceptor takes it, the in-service status bit (remote-IRR) is set. That bit blocks every further level request until it is cleared, and software cannot write it. On controller versions 0x20 and later, the bit is cleared by an EOI write whose vector matches the entry while the entry is in level mode. On older versions, which have no EOI register, rewriting the entry with edge trigger clears it. A reset routine that only masks the slot therefore leaves a stale remote-IRR in place, and must use one of these two paths.

Top module: `irq_route_entry`

## Requirements
- R1: After reset the entry reads 0x400: bit 10 (mask) = 1, bit 9 (trigger, 1 = level) = 0, bit 8 (routing, 1 = system-management) = 0, bits 7:0 (vector) = 0, bit 11 (remote-IRR) = 0. No request is pending.
- R2: A write with reg_sel = 0 loads vector, routing, trigger and mask from the same bit positions. Bit 11 of the write data is ignored, and remote-IRR rises only through an accepted level delivery.
- R3: In edge mode, req_valid rises the cycle after the cycle in which the line is first seen high. There is exactly one delivery per rising edge. While req_ready is low, the request holds with a stable vector.
- R4: In level mode, req_valid is high in the same cycle the line is high, provided the entry is unmasked and remote-IRR is clear. Acceptance sets remote-IRR at that clock edge.
- R5: While remote-IRR is set, a level-mode entry issues no request, even with the line held high.
- R6: With VERSION >= 0x20, a write with reg_sel = 1 whose bits 7:0 equal the entry's vector clears remote-IRR, provided the entry is in level mode.
- R7: An EOI write with a different vector, or made while the entry is in edge mode, or made on a version below 0x20, leaves remote-IRR unchanged.
- R8: With VERSION < 0x20, an entry write with bit 9 = 0 clears remote-IRR. A later write back to level mode leaves it clear.
- R9: A set mask suppresses every request, and a rising edge seen while masked is discarded. Remote-IRR keeps its value while masked.
- R10: req_vector carries the entry's vector, and req_smi carries its routing bit, on every delivery.
- R11: With VERSION >= 0x20, entry writes never clear remote-IRR. This includes a write of 0x400, which clears vector, trigger and routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = entry, 1 = EOI register |
| reg_wdata | input | VEC_W+4 | Write data |
| reg_rdata | output | VEC_W+4 | Entry readback, remote-IRR in the top bit |
| irq_line | input | 1 | Device interrupt line |
| req_valid | output | 1 | Delivery request |
| req_ready | input | 1 | Acceptor takes the request at this edge |
| req_vector | output | VEC_W | Vector of the request |
| req_smi | output | 1 | Request is system-management routed |

## Verification
Results fall due at three different points after a stimulus:
- A level request appears in the same cycle the line goes high.
- An edge request appears one clock after the line is seen high.
- A register write shows on the readback one clock after its strobe.

Inputs change only on falling edges. The delivery monitor samples valid and ready 2 ns later, just before the accepting rising edge, and matches each acceptance against the scoreboard queue in order. Readback and "no request" checks sample one full falling edge after the write or line change. By then every edge-detect and remote-IRR register on the path has settled. Two instances built for the old and new versions see the same stimulus, each with its own expectations.

// File: rtl/irq_route_entry.sv
module irq_route_entry #(
  parameter int VEC_W   = 8,
  parameter int VERSION = 32'h20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [VEC_W+3:0] reg_wdata,
  output logic [VEC_W+3:0] reg_rdata,
  input  logic             irq_line,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [VEC_W-1:0] req_vector,
  output logic             req_smi
);
  localparam int SMI_B = VEC_W;
  localparam int LVL_B = VEC_W + 1;
  localparam int MSK_B = VEC_W + 2;
  localparam int IRR_B = VEC_W + 3;
  localparam bit HAS_EOI = (VERSION >= 32'h20);

  logic [VEC_W-1:0] vector;
  logic smi, lvl, mask, rirr, pend, line_q;

  wire ent_wr   = reg_wr & ~reg_sel;
  wire eoi_wr   = reg_wr & reg_sel;
  wire rise     = irq_line & ~line_q;
  wire accept   = req_valid & req_ready;
  wire eoi_hit  = HAS_EOI && eoi_wr && lvl && (reg_wdata[VEC_W-1:0] == vector);
  wire edge_hit = !HAS_EOI && ent_wr && !reg_wdata[LVL_B];
  wire unused_ro = reg_wdata[IRR_B];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vector <= '0;
      smi    <= 1'b0;
      lvl    <= 1'b0;
      mask   <= 1'b1;
    end else if (ent_wr) begin
      vector <= reg_wdata[VEC_W-1:0];
      smi    <= reg_wdata[SMI_B];
      lvl    <= reg_wdata[LVL_B];
      mask   <= reg_wdata[MSK_B];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= irq_line;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            pend <= 1'b0;
    else if (mask || lvl)  pend <= 1'b0;
    else if (rise)         pend <= 1'b1;
    else if (accept)       pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  rirr <= 1'b0;
    else if (accept && lvl)      rirr <= 1'b1;
    else if (eoi_hit || edge_hit) rirr <= 1'b0;
  end

  assign req_valid  = !mask && (lvl ? (irq_line && !rirr) : pend);
  assign req_vector = vector;
  assign req_smi    = smi;
  assign reg_rdata  = {rirr, mask, lvl, smi, vector};
endmodule

// File: rtl/irq_route_entry_chk.sv
module irq_route_entry_chk #(
  parameter int VEC_W   = 8,
  parameter int VERSION = 32'h20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_sel,
  input logic [VEC_W+3:0] reg_wdata,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VEC_W-1:0] req_vector,
  input logic [VEC_W-1:0] vector,
  input logic             lvl,
  input logic             rirr
);
  localparam bit HAS_EOI = (VERSION >= 32'h20);

  AST_LEVEL_ACCEPT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && lvl) |=> rirr); // R4
  AST_RIRR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rirr && lvl) |-> !req_valid); // R5
  AST_RIRR_RISE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rirr) |-> $past(req_valid && req_ready && lvl)); // R2
  AST_EOI_MISMATCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && rirr && reg_wdata[VEC_W-1:0] != vector) |=> rirr); // R7
  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !lvl && !reg_wr) |=> (req_valid && $stable(req_vector))); // R3
  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_EOI && reg_wr && reg_sel && lvl && rirr && reg_wdata[VEC_W-1:0] == vector) |=> !rirr); // R6
endmodule

bind irq_route_entry irq_route_entry_chk #(.VEC_W(VEC_W), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .req_valid(req_valid), .req_ready(req_ready), .req_vector(req_vector),
  .vector(vector), .lvl(lvl), .rirr(rirr)
);

// File: tb/test_irq_route_entry.sv
`timescale 1ns/100ps
module test_irq_route_entry;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0, irq_line = 1'b0, req_ready = 1'b1;
  logic [11:0] reg_wdata = '0;
  logic [11:0] rd_new, rd_old;
  logic v_new, v_old, s_new, s_old;
  logic [7:0] vec_new, vec_old;
  int compared = 0, mismatched = 0;
  bit done = 1'b0;
  logic [8:0] q_new[$], q_old[$];

  always #2.5 clk = ~clk;

  irq_route_entry #(.VEC_W(8), .VERSION(32'h20)) i_irq_route_entry (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(rd_new), .irq_line(irq_line), .req_valid(v_new), .req_ready(req_ready),
    .req_vector(vec_new), .req_smi(s_new));

  irq_route_entry #(.VEC_W(8), .VERSION(32'h11)) i_irq_route_entry_old (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(rd_old), .irq_line(irq_line), .req_valid(v_old), .req_ready(req_ready),
    .req_vector(vec_old), .req_smi(s_old));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [11:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [11:0] en, input logic [11:0] eo);
    @(negedge clk); #1;
    chk({tag, " new readback"}, 32'(rd_new), 32'(en));
    chk({tag, " old readback"}, 32'(rd_old), 32'(eo));
  endtask

  task automatic line(input logic v, input int hold);
    @(negedge clk); irq_line = v;
    repeat (hold) @(negedge clk);
  endtask

  task automatic expect_both(input logic [8:0] item);
    q_new.push_back(item); q_old.push_back(item);
  endtask

  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n && v_new && req_ready) begin
        if (q_new.size() == 0) begin
          compared++; mismatched++;
          $display("FAIL R3/R4/R5 new unexpected delivery: actual %h expected none", {s_new, vec_new});
        end else chk("R10 new delivery", 32'({s_new, vec_new}), 32'(q_new.pop_front()));
      end
      if (rst_n && v_old && req_ready) begin
        if (q_old.size() == 0) begin
          compared++; mismatched++;
          $display("FAIL R3/R4/R5 old unexpected delivery: actual %h expected none", {s_old, vec_old});
        end else chk("R10 old delivery", 32'({s_old, vec_old}), 32'(q_old.pop_front()));
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd("R1", 12'h400, 12'h400);
    chk("R1 no request", 32'({v_new, v_old}), 32'h0);

    wr(1'b0, 12'h831);
    rd("R2 read-only bit", 12'h031, 12'h031);

    expect_both(9'h031);
    line(1'b1, 5);
    line(1'b0, 2);

    req_ready = 1'b0;
    expect_both(9'h031);
    line(1'b1, 3);
    #1 chk("R3 held request", 32'(v_new), 32'h1);
    chk("R3 held vector", 32'(vec_new), 32'h31);
    line(1'b0, 1);
    @(negedge clk); req_ready = 1'b1;
    repeat (3) @(negedge clk);

    wr(1'b0, 12'h245);
    expect_both(9'h045);
    line(1'b1, 3);
    rd("R4 remote-IRR set", 12'ha45, 12'ha45);
    chk("R5 blocked", 32'({v_new, v_old}), 32'h0);
    line(1'b0, 1);

    wr(1'b1, 12'h044);
    rd("R7 mismatched EOI", 12'ha45, 12'ha45);
    wr(1'b1, 12'h045);
    rd("R6 EOI clears / R7 old ignores", 12'h245, 12'ha45);

    wr(1'b0, 12'h645);
    rd("R9 masked", 12'h645, 12'he45);
    line(1'b1, 3);
    chk("R9 mask suppresses", 32'({v_new, v_old}), 32'h0);
    q_new.push_back(9'h045);
    wr(1'b0, 12'h245);
    wr(1'b0, 12'h645);
    rd("R9 remote-IRR kept while masked", 12'he45, 12'he45);
    line(1'b0, 1);

    wr(1'b0, 12'h445);
    rd("R11 new keeps / R8 old edge clears", 12'hc45, 12'h445);
    wr(1'b1, 12'h045);
    rd("R7 EOI in edge mode", 12'hc45, 12'h445);
    wr(1'b0, 12'h645);
    rd("R8 back to level stays clear", 12'he45, 12'h645);
    wr(1'b0, 12'h400);
    rd("R11 masked zero write", 12'hc00, 12'h400);

    wr(1'b0, 12'h645);
    wr(1'b1, 12'h045);
    rd("R6 EOI clears again", 12'h645, 12'h645);

    wr(1'b0, 12'h577);
    line(1'b1, 3);
    line(1'b0, 1);
    chk("R9 masked edge", 32'({v_new, v_old}), 32'h0);
    wr(1'b0, 12'h177);
    repeat (3) @(negedge clk);
    chk("R9 dropped edge", 32'({v_new, v_old}), 32'h0);
    expect_both(9'h177);
    line(1'b1, 3);
    line(1'b0, 3);

    repeat (5) @(negedge clk);
    chk("R3/R4 new missing deliveries", 32'(q_new.size()), 32'h0);
    chk("R3/R4 old missing deliveries", 32'(q_old.size()), 32'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule